// File: doc/BRIEF.md
# Frame-Type Parser Context Switcher

This block watches the 16-bit type field of each arriving frame. It decides whether the downstream parser chain is already set up for that type. A small table, supplied on input ports, lists the supported type values. Each entry has an enable bit and a context index that names a pre-stored parser configuration. A frame whose context is already loaded and ready is accepted. A frame whose type has no enabled table entry is flagged as unsupported and does not change the parser.

A frame of a supported type whose context is not loaded starts a reconfiguration. The block requests the stored configuration for each parser core in turn from an external configuration store, using a request/done handshake indexed by context and core. When the store acknowledges the last core, the parser is declared ready for the new context. Supported-type frames that cannot be handled during this time are dropped and counted in a saturating counter, which a control input can clear.

The controller has three states: `ST_EMPTY` (nothing loaded since reset), `ST_FETCH` (a reconfiguration in progress) and `ST_READY` (a context loaded). The transitions are:
- EMPTY→FETCH on a supported frame.
- READY→FETCH on a supported frame for a context other than the loaded one.
- FETCH→FETCH, advancing one core, on each acknowledgement that is not for the last core.
- FETCH→READY on the acknowledgement for the last core.

Every other case holds the state.

Top module: `ctx_switcher`

## Requirements
- R1: Table entry i occupies bits [16*i+15:16*i] of `tbl_etype` and bits [CTX_W*i+CTX_W-1:CTX_W*i] of `tbl_ctx`, and is enabled by `tbl_en[i]`. A frame type matches an entry when the two 16-bit values are equal and the entry is enabled. When several enabled entries match, the lowest index supplies the context. A disabled entry never matches.
- R2: A matching frame that arrives in `ST_READY` with its context equal to `active_ctx` pulses `frm_accept` for one cycle, in the cycle after it is sampled. The counter and the state are left unchanged.
- R3: A frame with no matching entry pulses `frm_unsup` in the cycle after it is sampled. It does not start a reconfiguration, does not change state, fetch or ready outputs, and does not change the counter.
- R4: A matching frame that is not accepted, arriving in `ST_EMPTY` or `ST_READY`, has the following effect in the next cycle: `busy`=1, `ready`=0, `fetch_req`=1, `fetch_ctx` equal to the frame's context and `fetch_core`=0. The frame is counted as unhandled.
- R5: Cores are fetched in index order, from 0 to NUM_CORES-1. `fetch_core` advances by one only after a cycle in which `fetch_done`=1 while `fetch_req`=1. Otherwise the request, core index and context are held. `fetch_done` outside a request has no effect.
- R6: In the cycle after `fetch_done` is sampled for core NUM_CORES-1, the outputs are `busy`=0, `ready`=1, `fetch_req`=0, and `active_ctx` equals the fetched context.
- R7: Only one reconfiguration runs at a time. Any matching frame sampled in `ST_FETCH` is counted as unhandled and leaves `fetch_ctx` unchanged.
- R8: `unhandled_cnt` increases by one for each unhandled frame and stops at 2^CNT_W-1 without wrapping.
- R9: `clr_cnt` sets the counter to 0 in the next cycle. It takes priority over an increment in the same cycle.
- R10: After reset the outputs are `busy`=0, `ready`=0, `fetch_req`=0, `frm_accept`=0, `frm_unsup`=0 and `unhandled_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A frame type is presented this cycle |
| frm_etype | input | 16 | Type field of the frame, big-endian value |
| tbl_etype | input | 16*NUM_TYPES | Supported type values, entry i at bits 16*i |
| tbl_ctx | input | CTX_W*NUM_TYPES | Context index per entry |
| tbl_en | input | NUM_TYPES | Entry enable bits |
| clr_cnt | input | 1 | Clear the unhandled counter |
| fetch_done | input | 1 | Store acknowledges the current core |
| fetch_req | output | 1 | Request configuration of one core |
| fetch_ctx | output | CTX_W | Context being fetched |
| fetch_core | output | CORE_W | Core being configured |
| busy | output | 1 | Reconfiguration in progress |
| ready | output | 1 | Parser loaded with `active_ctx` |
| active_ctx | output | CTX_W | Loaded context |
| frm_accept | output | 1 | Frame handled (one-cycle pulse) |
| frm_unsup | output | 1 | Frame type not supported (one-cycle pulse) |
| unhandled_cnt | output | CNT_W | Saturating count of dropped frames |

## Verification
Every result of a frame sampled at a clock edge is registered. The accept or unsupported pulse, the counter step and the start of fetching therefore all appear one cycle after that edge. A done acknowledgement likewise shows as the next core index, or as ready, one cycle later. The bench drives frames and acknowledgements on the falling edge. A behavioural model advances on the rising edge from the same inputs, and every output is compared with that model on the following falling edge, so each comparison lands exactly one register stage after its cause. Directed checks take place on the same falling edge that ends each stimulus.

// File: rtl/ctx_sw_pkg.sv
package ctx_sw_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FETCH = 2'd1,
        ST_READY = 2'd2
    } sw_state_e;
endpackage

// File: rtl/etype_lookup.sv
module etype_lookup #(
    parameter int NUM_TYPES = 4,
    parameter int CTX_W     = 3
) (
    input  logic [15:0]                etype,
    input  logic [16*NUM_TYPES-1:0]    tbl_etype,
    input  logic [CTX_W*NUM_TYPES-1:0] tbl_ctx,
    input  logic [NUM_TYPES-1:0]       tbl_en,
    output logic                       hit,
    output logic [CTX_W-1:0]           hit_ctx
);
    logic [NUM_TYPES-1:0] match;

    for (genvar i = 0; i < NUM_TYPES; i++) begin : g_cmp
        assign match[i] = tbl_en[i] && (tbl_etype[16*i +: 16] == etype);
    end

    // scan from the top so the lowest matching index is the one kept
    always_comb begin
        hit     = 1'b0;
        hit_ctx = '0;
        for (int i = NUM_TYPES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_ctx = tbl_ctx[CTX_W*i +: CTX_W];
            end
        end
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (clr)                   count <= '0;
        else if (inc && count != MAXV)  count <= count + 1'b1;
    end
endmodule

// File: rtl/ctx_fsm.sv
module ctx_fsm
    import ctx_sw_pkg::*;
#(
    parameter int CTX_W     = 3,
    parameter int NUM_CORES = 8,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              hit,
    input  logic [CTX_W-1:0]  hit_ctx,
    input  logic              fetch_done,
    output logic              fetch_req,
    output logic [CTX_W-1:0]  fetch_ctx,
    output logic [CORE_W-1:0] fetch_core,
    output logic              busy,
    output logic              ready,
    output logic [CTX_W-1:0]  active_ctx,
    output logic              frm_accept,
    output logic              frm_unsup,
    output logic              miss
);
    localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(NUM_CORES - 1);

    sw_state_e state_q, state_d;
    logic      accept_now, start_now, core_ack;

    assign accept_now = frm_valid && hit && (state_q == ST_READY) && (hit_ctx == active_ctx);
    assign miss       = frm_valid && hit && !accept_now;
    assign start_now  = miss && (state_q != ST_FETCH);
    assign core_ack   = (state_q == ST_FETCH) && fetch_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (start_now) state_d = ST_FETCH;
            ST_FETCH: if (core_ack && fetch_core == LAST_CORE) state_d = ST_READY;
            ST_READY: if (start_now) state_d = ST_FETCH;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_ctx  <= '0;
            fetch_core <= '0;
            active_ctx <= '0;
            frm_accept <= 1'b0;
            frm_unsup  <= 1'b0;
        end else begin
            frm_accept <= accept_now;
            frm_unsup  <= frm_valid && !hit;
            if (start_now) begin
                fetch_ctx  <= hit_ctx;
                fetch_core <= '0;
            end else if (core_ack) begin
                if (fetch_core == LAST_CORE) active_ctx <= fetch_ctx;
                else                         fetch_core <= fetch_core + 1'b1;
            end
        end
    end

    always_comb begin
        fetch_req = (state_q == ST_FETCH);
        busy      = (state_q == ST_FETCH);
        ready     = (state_q == ST_READY);
    end
endmodule

// File: rtl/ctx_switcher.sv
module ctx_switcher #(
    parameter int NUM_TYPES = 4,
    parameter int CTX_W     = 3,
    parameter int NUM_CORES = 8,
    parameter int CNT_W     = 8,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frm_valid,
    input  logic [15:0]                frm_etype,
    input  logic [16*NUM_TYPES-1:0]    tbl_etype,
    input  logic [CTX_W*NUM_TYPES-1:0] tbl_ctx,
    input  logic [NUM_TYPES-1:0]       tbl_en,
    input  logic                       clr_cnt,
    input  logic                       fetch_done,
    output logic                       fetch_req,
    output logic [CTX_W-1:0]           fetch_ctx,
    output logic [CORE_W-1:0]          fetch_core,
    output logic                       busy,
    output logic                       ready,
    output logic [CTX_W-1:0]           active_ctx,
    output logic                       frm_accept,
    output logic                       frm_unsup,
    output logic [CNT_W-1:0]           unhandled_cnt
);
    logic             hit, miss;
    logic [CTX_W-1:0] hit_ctx;

    etype_lookup #(.NUM_TYPES(NUM_TYPES), .CTX_W(CTX_W)) u_lookup (
        .etype(frm_etype), .tbl_etype(tbl_etype), .tbl_ctx(tbl_ctx),
        .tbl_en(tbl_en), .hit(hit), .hit_ctx(hit_ctx)
    );

    ctx_fsm #(.CTX_W(CTX_W), .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .hit(hit),
        .hit_ctx(hit_ctx), .fetch_done(fetch_done), .fetch_req(fetch_req),
        .fetch_ctx(fetch_ctx), .fetch_core(fetch_core), .busy(busy),
        .ready(ready), .active_ctx(active_ctx), .frm_accept(frm_accept),
        .frm_unsup(frm_unsup), .miss(miss)
    );

    sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(miss), .count(unhandled_cnt)
    );
endmodule

// File: rtl/ctx_sw_chk.sv
module ctx_sw_chk #(
    parameter int CTX_W     = 3,
    parameter int NUM_CORES = 8,
    parameter int CNT_W     = 8,
    parameter int CORE_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_cnt,
    input logic              fetch_done,
    input logic              fetch_req,
    input logic [CTX_W-1:0]  fetch_ctx,
    input logic [CORE_W-1:0] fetch_core,
    input logic              busy,
    input logic              ready,
    input logic              frm_accept,
    input logic              frm_unsup,
    input logic [CNT_W-1:0]  unhandled_cnt
);
    localparam logic [CORE_W-1:0] LAST = CORE_W'(NUM_CORES - 1);
    localparam logic [CNT_W-1:0]  MAXV = '1;

    AST_CORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_done && fetch_core != LAST |=> fetch_req && fetch_core == $past(fetch_core) + CORE_W'(1)); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_done |=> fetch_req && $stable(fetch_core) && $stable(fetch_ctx)); // R5
    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_done && fetch_core == LAST |=> ready && !busy); // R6
    AST_ONE_RECONF: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(fetch_done && fetch_core == LAST) |=> busy && $stable(fetch_ctx)); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled_cnt == MAXV && !clr_cnt |=> unhandled_cnt == MAXV); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> unhandled_cnt == '0); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_accept && frm_unsup)); // R2
endmodule

bind ctx_switcher ctx_sw_chk #(
    .CTX_W(CTX_W), .NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .CORE_W(CORE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .fetch_done(fetch_done),
    .fetch_req(fetch_req), .fetch_ctx(fetch_ctx), .fetch_core(fetch_core),
    .busy(busy), .ready(ready), .frm_accept(frm_accept), .frm_unsup(frm_unsup),
    .unhandled_cnt(unhandled_cnt)
);

// File: tb/sim_ctx_switcher.sv
`timescale 1ns/1ps
module sim_ctx_switcher;
    localparam int NT = 4, CW = 3, NC = 8, CNW = 8, CRW = 3;
    localparam int CMAX = 255;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_valid = 1'b0, clr_cnt = 1'b0, fetch_done = 1'b0;
    logic [15:0] frm_etype = '0;
    logic [16*NT-1:0] tbl_etype;
    logic [CW*NT-1:0] tbl_ctx;
    logic [NT-1:0] tbl_en;
    logic fetch_req, busy, ready, frm_accept, frm_unsup;
    logic [CW-1:0] fetch_ctx, active_ctx;
    logic [CRW-1:0] fetch_core;
    logic [CNW-1:0] unhandled_cnt;

    always #4 clk = ~clk;

    ctx_switcher #(.NUM_TYPES(NT), .CTX_W(CW), .NUM_CORES(NC), .CNT_W(CNW)) u0 (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_etype(frm_etype),
        .tbl_etype(tbl_etype), .tbl_ctx(tbl_ctx), .tbl_en(tbl_en), .clr_cnt(clr_cnt),
        .fetch_done(fetch_done), .fetch_req(fetch_req), .fetch_ctx(fetch_ctx),
        .fetch_core(fetch_core), .busy(busy), .ready(ready), .active_ctx(active_ctx),
        .frm_accept(frm_accept), .frm_unsup(frm_unsup), .unhandled_cnt(unhandled_cnt)
    );

    int errors = 0, checks = 0;
    bit started = 0, finished = 0;
    int t_et [NT] = '{16'h0800, 16'h86DD, 16'h88CC, 16'h0800};
    int t_cx [NT] = '{1, 2, 3, 5};
    bit t_en [NT] = '{1, 1, 0, 1};

    // reference model: 0 empty, 1 fetching, 2 ready
    int m_state, m_core, m_tgt, m_act, m_cnt;
    bit m_acc, m_uns;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_state = 0; m_core = 0; m_tgt = 0; m_act = 0; m_cnt = 0; m_acc = 0; m_uns = 0;
        end else begin
            bit hit, inc, start;
            int cx;
            hit = 0; cx = 0; inc = 0; start = 0;
            for (int i = NT - 1; i >= 0; i--)
                if (t_en[i] && t_et[i] == int'(frm_etype)) begin hit = 1; cx = t_cx[i]; end
            m_acc = 0; m_uns = 0;
            if (frm_valid) begin
                if (!hit) m_uns = 1;
                else if (m_state == 2 && cx == m_act) m_acc = 1;
                else begin inc = 1; if (m_state != 1) start = 1; end
            end
            if (m_state == 1) begin
                if (fetch_done) begin
                    if (m_core == NC - 1) begin m_state = 2; m_act = m_tgt; end
                    else m_core++;
                end
            end else if (start) begin
                m_state = 1; m_tgt = cx; m_core = 0;
            end
            if (clr_cnt) m_cnt = 0;
            else if (inc && m_cnt < CMAX) m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R6 busy", int'(busy), int'(m_state == 1));
            chk("R6 ready", int'(ready), int'(m_state == 2));
            chk("R5 fetch_req", int'(fetch_req), int'(m_state == 1));
            if (m_state == 1) begin
                chk("R7 fetch_ctx", int'(fetch_ctx), m_tgt);
                chk("R5 fetch_core", int'(fetch_core), m_core);
            end
            if (m_state == 2) chk("R6 active_ctx", int'(active_ctx), m_act);
            chk("R2 accept", int'(frm_accept), int'(m_acc));
            chk("R3 unsup", int'(frm_unsup), int'(m_uns));
            chk("R8 count", int'(unhandled_cnt), m_cnt);
        end
    end

    // configuration store: acknowledges after lat waiting cycles unless stalled
    int lat = 2, wcnt = 0;
    bit stall = 0, spur = 0;
    always @(negedge clk) begin
        if (fetch_req && !stall) begin
            if (wcnt >= lat) begin fetch_done <= 1'b1; wcnt = 0; end
            else begin fetch_done <= 1'b0; wcnt++; end
        end else fetch_done <= spur;
    end

    task automatic send(input logic [15:0] et);
        @(negedge clk);
        frm_valid = 1'b1; frm_etype = et;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) begin
            tbl_etype[16*i +: 16] = t_et[i][15:0];
            tbl_ctx[CW*i +: CW]   = t_cx[i][CW-1:0];
            tbl_en[i]             = t_en[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 ready", int'(ready), 0);
        chk("R10 cnt", int'(unhandled_cnt), 0);

        send(16'h0806);                       // R3 unknown type
        chk("R3 flag", int'(frm_unsup), 1);
        chk("R3 no start", int'(busy), 0);

        send(16'h0800);                       // R4 start for context 1 (lowest index, R1)
        chk("R4 busy", int'(busy), 1);
        chk("R1 ctx lowest index", int'(fetch_ctx), 1);
        chk("R4 core0", int'(fetch_core), 0);
        chk("R4 cnt", int'(unhandled_cnt), 1);

        send(16'h86DD);                       // R7 during fetch
        chk("R7 ctx kept", int'(fetch_ctx), 1);
        send(16'h0800);
        send(16'h1234);
        chk("R7 cnt", int'(unhandled_cnt), 3);
        wait_ready();
        chk("R6 ready", int'(ready), 1);
        chk("R6 active", int'(active_ctx), 1);

        send(16'h0800);                       // R2 accepted
        chk("R2 accept", int'(frm_accept), 1);
        @(negedge clk); frm_valid = 1'b1; frm_etype = 16'h0800;
        @(negedge clk); frm_etype = 16'h0800;
        @(negedge clk); frm_valid = 1'b0;
        chk("R2 cnt unchanged", int'(unhandled_cnt), 3);

        send(16'h88CC);                       // R1 disabled entry
        chk("R1 disabled", int'(frm_unsup), 1);
        chk("R1 still ready", int'(ready), 1);

        spur = 1; repeat (3) @(negedge clk); spur = 0;   // R5 stray done ignored
        chk("R5 stray done", int'(busy), 0);

        lat = 0;
        send(16'h86DD);                       // R4 switch to context 2
        chk("R4 ctx2", int'(fetch_ctx), 2);
        wait_ready();
        chk("R6 active2", int'(active_ctx), 2);

        stall = 1; lat = 1;
        send(16'h0800);
        for (int i = 0; i < 300; i++) begin  // R8 saturation
            @(negedge clk); frm_valid = 1'b1; frm_etype = 16'h0800;
        end
        @(negedge clk); frm_valid = 1'b0;
        chk("R8 saturated", int'(unhandled_cnt), CMAX);
        @(negedge clk); frm_valid = 1'b1; clr_cnt = 1'b1;  // R9 clear beats increment
        @(negedge clk); frm_valid = 1'b0; clr_cnt = 1'b0;
        chk("R9 cleared", int'(unhandled_cnt), 0);
        stall = 0;
        wait_ready();
        chk("R6 active1", int'(active_ctx), 1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule